// File: doc/BRIEF.md
# SWD Line Reset and Wake Sequencer

This block produces the fixed serial bit streams that bring a debug port into two-wire serial debug operation. A single-cycle start pulse, together with a two-bit sequence code, launches one of four streams. The streams are a plain line reset, a line reset with an idle tail, the dormant-state wake stream and the legacy JTAG-to-SWD switch stream. The block clocks the stream out on the debug clock and data pins, least significant bit first, and raises a one-cycle done pulse after the last bit.

Each stream is built from short segments. A segment is either a run of constant level or a pattern of up to 32 bits. A sequence table sends the segments one after another, and a single bit-serial shifter sends each segment. The shifter divides the system clock by a parameter so that each debug clock phase lasts HALF_CYC system cycles. Data changes only while the debug clock is low.

The pins are shared with the transaction engine. While a stream runs, the block owns the pins and the engine's pin drive is ignored. When the block is idle, the engine's clock, data and output enable pass through unchanged.

Top module: `swd_wake_seq`

## Requirements
- R1: After reset, own_o and done_o are 0, and swclk_o, swdio_o and swdio_oe_o equal the engine inputs eng_swclk_i, eng_swdio_i and eng_swdio_oe_i.
- R2: Code seq_sel_i = 2'b00 sends a line reset: 60 bits high (LR_HIGH_BITS) and nothing else.
- R3: Code 2'b01 sends 60 bits high followed by 4 bits low (IDLE_BITS).
- R4: Code 2'b10 sends the wake stream in this order: 60 high bits, then the 128-bit alert pattern (default 128'h19BC0EA2_E3DDAFE9_86852D95_6209F392, bit 0 first), then one 12-bit word holding 4 zero bits in [3:0] and the 8-bit activation code (default 8'h1A) in [11:4], then 60 high bits, then 4 low bits.
- R5: Code 2'b11 sends 60 high bits, then the 16-bit select pattern (default 16'hE79E, bit 0 first), then 60 high bits, then 4 low bits.
- R6: Each bit lasts 2*HALF_CYC system cycles: swclk_o is low for HALF_CYC cycles and then high for HALF_CYC cycles. swdio_o changes only while swclk_o is low, and swdio_oe_o is 1 at every rising edge of swclk_o while the block owns the pins. Segments follow one another with no gap.
- R7: If start is sampled at clock edge E0 and the stream has N bits, done_o is 1 for exactly the one cycle that follows edge E0 + 2*HALF_CYC*N.
- R8: own_o is 1 from edge E0 until the edge at which done_o rises, and 0 from that edge on. While own_o is 1, the engine inputs have no effect on the pins.
- R9: A start pulse received while own_o is 1 is ignored. The running stream, its length and its done timing do not change.
- R10: When own_o is 0 after a stream has finished, the pins again follow the engine inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| seq_sel_i | input | 2 | Sequence code: 00 reset, 01 reset+idle, 10 wake, 11 JTAG switch |
| eng_swclk_i | input | 1 | Transaction engine debug clock |
| eng_swdio_i | input | 1 | Transaction engine data out |
| eng_swdio_oe_i | input | 1 | Transaction engine data output enable |
| swclk_o | output | 1 | Debug clock pin |
| swdio_o | output | 1 | Debug data pin value |
| swdio_oe_o | output | 1 | Debug data pin output enable |
| own_o | output | 1 | Block owns the pins; engine held off |
| done_o | output | 1 | One-cycle pulse after the final bit |

## Verification
The bench captures every bit on the rising edges of the pin clock and compares the stream bit by bit and by length. A missing idle tail, swapped alert words or an activation code at the wrong offset would show up as a length error or as the first differing bit. It counts the cycles from start to done for a divided clock. A gap between segments or a wrong half-period would move done away from 2*HALF_CYC*N+1. The engine clock toggles during runs, and a second start arrives mid-stream. A leaky pin mux would add extra captured edges, and a restart would shorten the stream. Pass-through to the engine is checked in reset and after each run, which catches a mux left stuck on the sequencer.

// File: rtl/swdseq_pkg.sv
package swdseq_pkg;

  localparam int SEG_LEN_W = 8;

  typedef enum logic [1:0] {
    SEQ_LR      = 2'd0,
    SEQ_LR_IDLE = 2'd1,
    SEQ_WAKE    = 2'd2,
    SEQ_J2S     = 2'd3
  } seq_code_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

  typedef struct packed {
    logic                 is_const;
    logic                 level;
    logic [31:0]          bits;
    logic [SEG_LEN_W-1:0] len;
    logic                 last;
  } seg_t;

endpackage

// File: rtl/swdseq_segrom.sv
module swdseq_segrom
  import swdseq_pkg::*;
#(
  parameter int           LR_HIGH_BITS = 60,
  parameter int           IDLE_BITS    = 4,
  parameter logic [127:0] ALERT_SEQ    = 128'h19BC0EA2_E3DDAFE9_86852D95_6209F392,
  parameter logic [7:0]   ACT_CODE     = 8'h1A,
  parameter logic [15:0]  J2S_SEQ      = 16'hE79E
) (
  input  seq_code_e  sel_i,
  input  logic [3:0] idx_i,
  output seg_t       seg_o
);

  localparam logic [SEG_LEN_W-1:0] HIGH_LEN = SEG_LEN_W'(LR_HIGH_BITS);
  localparam logic [SEG_LEN_W-1:0] IDLE_LEN = SEG_LEN_W'(IDLE_BITS);

  function automatic seg_t level_seg(input logic lvl, input logic [SEG_LEN_W-1:0] n,
                                     input logic fin);
    seg_t s;
    s.is_const = 1'b1;
    s.level    = lvl;
    s.bits     = {32{lvl}};
    s.len      = n;
    s.last     = fin;
    return s;
  endfunction

  function automatic seg_t word_seg(input logic [31:0] w, input logic [SEG_LEN_W-1:0] n);
    seg_t s;
    s.is_const = 1'b0;
    s.level    = 1'b0;
    s.bits     = w;
    s.len      = n;
    s.last     = 1'b0;
    return s;
  endfunction

  always_comb begin
    seg_o = level_seg(1'b0, SEG_LEN_W'(1), 1'b1);
    unique case (sel_i)
      SEQ_LR: begin
        seg_o = level_seg(1'b1, HIGH_LEN, 1'b1);
      end
      SEQ_LR_IDLE: begin
        if (idx_i == 4'd0) seg_o = level_seg(1'b1, HIGH_LEN, 1'b0);
        else               seg_o = level_seg(1'b0, IDLE_LEN, 1'b1);
      end
      SEQ_WAKE: begin
        case (idx_i)
          4'd0:    seg_o = level_seg(1'b1, HIGH_LEN, 1'b0);
          4'd1:    seg_o = word_seg(ALERT_SEQ[31:0],   SEG_LEN_W'(32));
          4'd2:    seg_o = word_seg(ALERT_SEQ[63:32],  SEG_LEN_W'(32));
          4'd3:    seg_o = word_seg(ALERT_SEQ[95:64],  SEG_LEN_W'(32));
          4'd4:    seg_o = word_seg(ALERT_SEQ[127:96], SEG_LEN_W'(32));
          4'd5:    seg_o = word_seg({20'd0, ACT_CODE, 4'd0}, SEG_LEN_W'(12));
          4'd6:    seg_o = level_seg(1'b1, HIGH_LEN, 1'b0);
          default: seg_o = level_seg(1'b0, IDLE_LEN, 1'b1);
        endcase
      end
      SEQ_J2S: begin
        case (idx_i)
          4'd0:    seg_o = level_seg(1'b1, HIGH_LEN, 1'b0);
          4'd1:    seg_o = word_seg({16'd0, J2S_SEQ}, SEG_LEN_W'(16));
          4'd2:    seg_o = level_seg(1'b1, HIGH_LEN, 1'b0);
          default: seg_o = level_seg(1'b0, IDLE_LEN, 1'b1);
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/swdseq_shifter.sv
module swdseq_shifter
  import swdseq_pkg::*;
#(
  parameter int HALF_CYC = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic                 ld_const_i,
  input  logic                 ld_level_i,
  input  logic [31:0]          ld_bits_i,
  input  logic [SEG_LEN_W-1:0] ld_len_i,
  output logic                 sclk_o,
  output logic                 sdo_o,
  output logic                 active_o,
  output logic                 seg_end_o
);

  localparam int HC_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic                 active_q, active_d;
  logic                 phase_q, phase_d;
  logic                 fill_q, fill_d;
  logic [31:0]          sh_q, sh_d;
  logic [SEG_LEN_W-1:0] cnt_q, cnt_d;
  logic                 half_end;

  generate
    if (HALF_CYC == 1) begin : g_nodiv
      assign half_end = 1'b1;
    end else begin : g_div
      logic [HC_W-1:0] hc_q, hc_d;
      always_comb begin
        hc_d = hc_q;
        if (load_i)                  hc_d = '0;
        else if (active_q) begin
          if (hc_q == HC_W'(HALF_CYC - 1)) hc_d = '0;
          else                             hc_d = hc_q + HC_W'(1);
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hc_q <= '0;
        else        hc_q <= hc_d;
      end
      assign half_end = (hc_q == HC_W'(HALF_CYC - 1));
    end
  endgenerate

  assign seg_end_o = active_q & phase_q & half_end & (cnt_q == '0);

  always_comb begin
    active_d = active_q;
    phase_d  = phase_q;
    fill_d   = fill_q;
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    if (load_i) begin
      active_d = 1'b1;
      phase_d  = 1'b0;
      fill_d   = ld_const_i & ld_level_i;
      sh_d     = ld_const_i ? {32{ld_level_i}} : ld_bits_i;
      cnt_d    = ld_len_i - SEG_LEN_W'(1);
    end else if (active_q && half_end) begin
      if (!phase_q) begin
        phase_d = 1'b1;
      end else begin
        phase_d = 1'b0;
        if (cnt_q == '0) begin
          active_d = 1'b0;
        end else begin
          cnt_d = cnt_q - SEG_LEN_W'(1);
          sh_d  = {fill_q, sh_q[31:1]};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      fill_q   <= 1'b0;
      sh_q     <= '0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      phase_q  <= phase_d;
      fill_q   <= fill_d;
      sh_q     <= sh_d;
      cnt_q    <= cnt_d;
    end
  end

  assign sclk_o   = phase_q;
  assign sdo_o    = sh_q[0];
  assign active_o = active_q;

  // R6
  data_stable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_q) |-> $stable(sh_q[0]));

  // R6
  clock_falls_after_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_end_o |=> !phase_q);

endmodule

// File: rtl/swd_wake_seq.sv
module swd_wake_seq
  import swdseq_pkg::*;
#(
  parameter int           LR_HIGH_BITS = 60,
  parameter int           IDLE_BITS    = 4,
  parameter int           HALF_CYC     = 1,
  parameter logic [127:0] ALERT_SEQ    = 128'h19BC0EA2_E3DDAFE9_86852D95_6209F392,
  parameter logic [7:0]   ACT_CODE     = 8'h1A,
  parameter logic [15:0]  J2S_SEQ      = 16'hE79E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] seq_sel_i,
  input  logic       eng_swclk_i,
  input  logic       eng_swdio_i,
  input  logic       eng_swdio_oe_i,
  output logic       swclk_o,
  output logic       swdio_o,
  output logic       swdio_oe_o,
  output logic       own_o,
  output logic       done_o
);

  run_state_e state_q, state_d;
  seq_code_e  sel_q, sel_d;
  logic [3:0] idx_q, idx_d;
  logic       last_q, last_d;
  logic       done_q, done_d;

  seq_code_e  rom_sel;
  logic [3:0] rom_idx;
  seg_t       seg;

  logic launch, advance, finish, load;
  logic sh_clk, sh_dat, sh_active, seg_end;

  assign rom_sel = (state_q == ST_IDLE) ? seq_code_e'(seq_sel_i) : sel_q;
  assign rom_idx = (state_q == ST_IDLE) ? 4'd0 : idx_q + 4'd1;

  swdseq_segrom #(
    .LR_HIGH_BITS(LR_HIGH_BITS),
    .IDLE_BITS   (IDLE_BITS),
    .ALERT_SEQ   (ALERT_SEQ),
    .ACT_CODE    (ACT_CODE),
    .J2S_SEQ     (J2S_SEQ)
  ) u_rom (
    .sel_i(rom_sel),
    .idx_i(rom_idx),
    .seg_o(seg)
  );

  assign launch  = (state_q == ST_IDLE) & start_i;
  assign advance = (state_q == ST_RUN) & seg_end & ~last_q;
  assign finish  = (state_q == ST_RUN) & seg_end & last_q;
  assign load    = launch | advance;

  swdseq_shifter #(
    .HALF_CYC(HALF_CYC)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .ld_const_i(seg.is_const),
    .ld_level_i(seg.level),
    .ld_bits_i (seg.bits),
    .ld_len_i  (seg.len),
    .sclk_o    (sh_clk),
    .sdo_o     (sh_dat),
    .active_o  (sh_active),
    .seg_end_o (seg_end)
  );

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    idx_d   = idx_q;
    last_d  = last_q;
    done_d  = finish;
    if (launch) begin
      state_d = ST_RUN;
      sel_d   = seq_code_e'(seq_sel_i);
      idx_d   = 4'd0;
    end else if (advance) begin
      idx_d = idx_q + 4'd1;
    end else if (finish) begin
      state_d = ST_IDLE;
    end
    if (load) last_d = seg.last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= SEQ_LR;
      idx_q   <= 4'd0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      done_q  <= done_d;
    end
  end

  assign own_o      = (state_q == ST_RUN);
  assign done_o     = done_q;
  assign swclk_o    = own_o ? sh_clk : eng_swclk_i;
  assign swdio_o    = own_o ? sh_dat : eng_swdio_i;
  assign swdio_oe_o = own_o ? 1'b1   : eng_swdio_oe_i;

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(own_o));

  // R8
  own_has_shifter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_o |-> sh_active);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_o && start_i && !finish) |=> (own_o && $stable(sel_q)));

endmodule

// File: tb/sim_swd_wake_seq.sv
`timescale 1ns/1ps
module sim_swd_wake_seq;

  localparam int           H      = 2;
  localparam int           LRH    = 60;
  localparam int           IDL    = 4;
  localparam logic [127:0] ALERT  = 128'h19BC0EA2_E3DDAFE9_86852D95_6209F392;
  localparam logic [7:0]   ACT    = 8'h1A;
  localparam logic [15:0]  J2S    = 16'hE79E;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, start, eng_clk, eng_dat, eng_oe;
  logic [1:0] seq_sel;
  logic       swclk_o, swdio_o, swdio_oe_o, own_o, done_o;

  swd_wake_seq #(
    .LR_HIGH_BITS(LRH), .IDLE_BITS(IDL), .HALF_CYC(H),
    .ALERT_SEQ(ALERT), .ACT_CODE(ACT), .J2S_SEQ(J2S)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .seq_sel_i(seq_sel),
    .eng_swclk_i(eng_clk), .eng_swdio_i(eng_dat), .eng_swdio_oe_i(eng_oe),
    .swclk_o(swclk_o), .swdio_o(swdio_o), .swdio_oe_o(swdio_oe_o),
    .own_o(own_o), .done_o(done_o)
  );

  int checks = 0;
  int errors = 0;
  bit exp_bits[0:511];
  int exp_n;
  bit got_bits[0:511];
  int got_n;
  int oe_bad;
  bit capturing = 0;
  bit noise = 0;

  always @(posedge swclk_o) begin
    if (capturing && own_o) begin
      if (!swdio_oe_o) oe_bad++;
      if (got_n < 512) got_bits[got_n] = swdio_o;
      got_n++;
    end
  end

  initial begin
    forever begin
      #3.3;
      if (noise) begin
        eng_clk = ~eng_clk;
        eng_dat = ~eng_dat;
        eng_oe  = ~eng_oe;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push_level(input bit lvl, input int n);
    for (int i = 0; i < n; i++) begin exp_bits[exp_n] = lvl; exp_n++; end
  endtask

  task automatic push_word(input logic [127:0] w, input int n);
    for (int i = 0; i < n; i++) begin exp_bits[exp_n] = w[i]; exp_n++; end
  endtask

  task automatic build_exp(input logic [1:0] sel);
    exp_n = 0;
    push_level(1'b1, LRH);
    case (sel)
      2'b01: push_level(1'b0, IDL);
      2'b10: begin
        push_word(ALERT, 128);
        push_word({116'd0, ACT, 4'd0}, 12);
        push_level(1'b1, LRH);
        push_level(1'b0, IDL);
      end
      2'b11: begin
        push_word({112'd0, J2S}, 16);
        push_level(1'b1, LRH);
        push_level(1'b0, IDL);
      end
      default: ;
    endcase
  endtask

  task automatic check_pass(input string req);
    for (int p = 0; p < 4; p++) begin
      eng_clk = p[0]; eng_dat = p[1]; eng_oe = p[0] ^ p[1];
      #1;
      check(swclk_o == eng_clk && swdio_o == eng_dat && swdio_oe_o == eng_oe, req,
            "pins follow engine", {swclk_o, swdio_o, swdio_oe_o},
            {eng_clk, eng_dat, eng_oe});
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; seq_sel = 2'b00;
    eng_clk = 1'b0; eng_dat = 1'b0; eng_oe = 1'b0;
    repeat (3) @(negedge clk);
    check(own_o == 1'b0, "R1", "own in reset", own_o, 0);
    check(done_o == 1'b0, "R1", "done in reset", done_o, 0);
    check_pass("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check(own_o == 1'b0 && done_o == 1'b0, "R1", "idle after reset",
          {own_o, done_o}, 0);
  endtask

  task automatic t_run(input logic [1:0] sel, input string req,
                       input bit with_noise, input bit poke);
    int cycles, own_gap, mism, first_bad;
    build_exp(sel);
    got_n = 0; oe_bad = 0; own_gap = 0;
    capturing = 1'b1;
    @(negedge clk);
    start = 1'b1; seq_sel = sel;
    @(negedge clk);
    start = 1'b0;
    noise = with_noise;
    cycles = 1;
    while (!done_o && cycles < 5000) begin
      if (!own_o) own_gap++;
      if (poke && (cycles == 40 || cycles == 300)) begin start = 1'b1; seq_sel = 2'b00; end
      else start = 1'b0;
      @(negedge clk);
      cycles++;
    end
    start = 1'b0;
    noise = 1'b0;
    check(done_o == 1'b1, req, "done seen", done_o, 1);
    check(cycles == 2 * H * exp_n + 1, "R7", "cycles to done", cycles, 2 * H * exp_n + 1);
    check(own_o == 1'b0 && own_gap == 0, "R8", "ownership window", own_gap + own_o, 0);
    check(oe_bad == 0, "R6", "output enable while owned", oe_bad, 0);
    check(got_n == exp_n, req, "bit count", got_n, exp_n);
    mism = 0; first_bad = -1;
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (got_bits[i] != exp_bits[i]) begin
        if (first_bad < 0) first_bad = i;
        mism++;
      end
    check(mism == 0, req, "bit mismatches (first index in note)", mism, 0);
    if (mism != 0) $display("  first differing bit index %0d", first_bad);
    @(negedge clk);
    check(done_o == 1'b0, "R7", "done lasts one cycle", done_o, 0);
    capturing = 1'b0;
    check_pass("R10");
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_run(2'b00, "R2", 1'b0, 1'b0);
    t_run(2'b01, "R3", 1'b0, 1'b0);
    t_run(2'b10, "R4", 1'b0, 1'b0);
    t_run(2'b11, "R5", 1'b0, 1'b0);
    t_run(2'b10, "R8", 1'b1, 1'b0);
    t_run(2'b11, "R9", 1'b1, 1'b1);
    t_run(2'b01, "R6", 1'b1, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule